// File: doc/BRIEF.md
# Eight-bit timer with programmable top and dual compare outputs

This block is an 8-bit up-counter with three compare registers. The first two compare registers, A and B, each drive an output pin through a 2-bit action code. The third register is the top of the count. A 4-bit clock-select field picks how many base-clock ticks make one timer step, and a prescaler-reset strobe restarts that division.

Software reaches every register through a single-cycle write port and a combinational read port. The caller supplies `tick` as the base-clock enable. Three sticky flags report overflow, compare A and compare B. Each flag is cleared by writing 1 to its bit.

The register map is as follows. Address 0 is pin control: [1:0] action A, [3:2] action B, [4] force A, [5] force B, [6] PWM enable A, [7] PWM enable B. Address 1 is clock control: [3:0] clock select, [4] prescaler reset, [5] clear at top. Address 2 is the counter. Addresses 3, 4 and 5 are compare A, compare B and top C. Address 6 holds the flags: [0] overflow, [1] compare A, [2] compare B.

Top module: `tmr8_tricmp`

## Requirements
- R1: Clock select 0 stops the counter. Code n from 1 to 15 advances it once every 2^(n-1) `tick` pulses.
- R2: Writing 1 to bit 4 of address 1 clears the prescaler. The bit always reads 0, and writing 0 to it does nothing.
- R3: Action codes apply on a match. 01 toggles the pin, 10 clears it and 11 sets it. Code 00 holds the pin's stored state and drives the output low.
- R4: A match with A or B happens only when the counter steps to the compare value. A counter write that makes the counter equal to a compare value sets no flag and changes no pin.
- R5: When clear-at-top or either PWM enable is set, the step after the counter reaches C takes it to 0. Otherwise it continues past C.
- R6: The overflow flag is set when the counter steps from 0xFF to 0, or from C to 0.
- R7: Writing 1 to a force bit applies that channel's action at once and sets no flag. An action code written in the same cycle is the one used. Force bits read 0.
- R8: A force bit has no effect while the PWM enable bit of that channel is set.
- R9: A counter write wins over a step in the same cycle, and counting resumes from the written value on the next timer step.
- R10: The flags are sticky, and writing 1 to a flag bit clears it.
- R11: Reset clears every register and flag, and drives both output pins low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-clock enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| oc_a | output | 1 | Compare output pin A |
| oc_b | output | 1 | Compare output pin B |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_cmp_a | output | 1 | Sticky compare-A flag |
| flag_cmp_b | output | 1 | Sticky compare-B flag |

## Verification
The assertions assume one write per cycle on a single address. They also assume that `tick` is the only source of timer steps, so flags can change only on a step or on a flag-register write. The stimulus drives inputs only on falling edges and holds `wr_en` and `tick` apart. It also chooses compare values that the count does not cross by accident, so that every flag that is set can be traced to one intended event.

// File: rtl/tmr8_tricmp.sv
module tmr8_tricmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       oc_a,
  output logic       oc_b,
  output logic       flag_ovf,
  output logic       flag_cmp_a,
  output logic       flag_cmp_b
);
  localparam int PSW = 14;
  localparam logic [2:0] A_PIN = 3'd0, A_CLK = 3'd1, A_CNT = 3'd2,
                         A_CA = 3'd3, A_CB = 3'd4, A_TOP = 3'd5, A_FLG = 3'd6;

  logic [1:0] act_a, act_b;
  logic       pwm_a, pwm_b, clr_top;
  logic [3:0] csel;
  logic [7:0] cnt, cmp_a, cmp_b, top;
  logic [PSW-1:0] ps, ps_mask;
  logic       pin_a, pin_b;

  wire wr_pin = wr_en && addr == A_PIN;
  wire wr_clk = wr_en && addr == A_CLK;
  wire wr_cnt = wr_en && addr == A_CNT;
  wire wr_flg = wr_en && addr == A_FLG;

  assign ps_mask = (csel == 4'd0) ? '0 : ((PSW'(1) << (csel - 4'd1)) - PSW'(1));
  wire step = tick && csel != 4'd0 && (ps & ps_mask) == ps_mask && !wr_cnt;

  wire wrap_en = clr_top || pwm_a || pwm_b;
  wire at_top  = wrap_en && cnt == top;
  wire [7:0] nxt = at_top ? 8'h00 : cnt + 8'h01;
  wire ovf_ev  = step && (at_top || cnt == 8'hFF);
  wire hit_a   = step && nxt == cmp_a;
  wire hit_b   = step && nxt == cmp_b;

  wire [1:0] new_act_a = wr_pin ? wr_data[1:0] : act_a;
  wire [1:0] new_act_b = wr_pin ? wr_data[3:2] : act_b;
  wire frc_a = wr_pin && wr_data[4] && !wr_data[6];
  wire frc_b = wr_pin && wr_data[5] && !wr_data[7];

  function automatic logic apply(input logic [1:0] code, input logic cur);
    case (code)
      2'b01:   apply = ~cur;
      2'b10:   apply = 1'b0;
      2'b11:   apply = 1'b1;
      default: apply = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a <= '0; act_b <= '0; pwm_a <= 1'b0; pwm_b <= 1'b0;
      csel <= '0; clr_top <= 1'b0;
      cmp_a <= '0; cmp_b <= '0; top <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PIN: begin
          act_a <= wr_data[1:0]; act_b <= wr_data[3:2];
          pwm_a <= wr_data[6];   pwm_b <= wr_data[7];
        end
        A_CLK: begin csel <= wr_data[3:0]; clr_top <= wr_data[5]; end
        A_CA:  cmp_a <= wr_data;
        A_CB:  cmp_b <= wr_data;
        A_TOP: top <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ps <= '0;
    else if (wr_clk && wr_data[4]) ps <= '0;
    else if (tick && csel != 4'd0) ps <= ps + PSW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= wr_data;
    else if (step)   cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_a <= 1'b0; pin_b <= 1'b0;
    end else begin
      if (hit_a || frc_a) pin_a <= apply(new_act_a, pin_a);
      if (hit_b || frc_b) pin_b <= apply(new_act_b, pin_b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_ovf <= 1'b0; flag_cmp_a <= 1'b0; flag_cmp_b <= 1'b0;
    end else begin
      if (ovf_ev) flag_ovf <= 1'b1;
      else if (wr_flg && wr_data[0]) flag_ovf <= 1'b0;
      if (hit_a) flag_cmp_a <= 1'b1;
      else if (wr_flg && wr_data[1]) flag_cmp_a <= 1'b0;
      if (hit_b) flag_cmp_b <= 1'b1;
      else if (wr_flg && wr_data[2]) flag_cmp_b <= 1'b0;
    end
  end

  assign oc_a = (act_a != 2'b00) && pin_a;
  assign oc_b = (act_b != 2'b00) && pin_b;

  always_comb begin
    case (addr)
      A_PIN:   rd_data = {pwm_b, pwm_a, 2'b00, act_b, act_a};
      A_CLK:   rd_data = {2'b00, clr_top, 1'b0, csel};
      A_CNT:   rd_data = cnt;
      A_CA:    rd_data = cmp_a;
      A_CB:    rd_data = cmp_b;
      A_TOP:   rd_data = top;
      A_FLG:   rd_data = {5'b0, flag_cmp_b, flag_cmp_a, flag_ovf};
      default: rd_data = 8'h00;
    endcase
  end

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 4'd0 && !wr_cnt) |=> $stable(cnt));

  // R4
  write_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> ($stable(flag_cmp_a) && $stable(flag_cmp_b) && $stable(flag_ovf)));

  // R5
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap_en && cnt == top) |=> cnt == 8'h00);

  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> ($past(cnt) == 8'hFF || $past(cnt) == $past(top)));

  // R8
  pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pin && wr_data[6] && !hit_a) |=> $stable(pin_a));
endmodule

// File: tb/test_tmr8_tricmp.sv
module test_tmr8_tricmp;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic oc_a, oc_b, flag_ovf, flag_cmp_a, flag_cmp_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tmr8_tricmp i_tmr8_tricmp (.clk, .rst_n, .tick, .wr_en, .addr, .wr_data,
    .rd_data, .oc_a, .oc_b, .flag_ovf, .flag_cmp_a, .flag_cmp_b);

  // op: 0 write, 1 read check, 2 run data ticks, 3 pins {oc_b,oc_a} check
  localparam int NV = 53;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0,4'd4,3'd4,8'h80},
    {2'd0,4'd1,3'd1,8'h01}, {2'd0,4'd3,3'd3,8'h03}, {2'd0,4'd3,3'd0,8'h01},
    {2'd2,4'd1,3'd0,8'd3},  {2'd1,4'd1,3'd2,8'h03}, {2'd1,4'd10,3'd6,8'h02},
    {2'd3,4'd3,3'd0,8'h01},                                   // R3 toggle
    {2'd0,4'd10,3'd6,8'h02}, {2'd1,4'd10,3'd6,8'h00},         // R10
    {2'd0,4'd4,3'd2,8'h03}, {2'd1,4'd4,3'd6,8'h00},           // R4
    {2'd3,4'd4,3'd0,8'h01}, {2'd1,4'd9,3'd2,8'h03},           // R4, R9
    {2'd0,4'd5,3'd5,8'h05}, {2'd0,4'd5,3'd1,8'h21},
    {2'd2,4'd5,3'd0,8'd2},  {2'd1,4'd5,3'd2,8'h05},
    {2'd2,4'd5,3'd0,8'd1},  {2'd1,4'd5,3'd2,8'h00}, {2'd1,4'd6,3'd6,8'h01}, // R5 R6
    {2'd0,4'd10,3'd6,8'h01},
    {2'd0,4'd7,3'd0,8'h12}, {2'd3,4'd7,3'd0,8'h00}, {2'd1,4'd7,3'd6,8'h00},
    {2'd1,4'd7,3'd0,8'h02},                                   // R7
    {2'd0,4'd8,3'd0,8'h53}, {2'd3,4'd8,3'd0,8'h00}, {2'd1,4'd8,3'd0,8'h43}, // R8
    {2'd0,4'd2,3'd0,8'h00}, {2'd0,4'd2,3'd1,8'h13}, {2'd0,4'd9,3'd2,8'h00},
    {2'd2,4'd2,3'd0,8'd3},  {2'd1,4'd2,3'd2,8'h00},
    {2'd2,4'd1,3'd0,8'd1},  {2'd1,4'd1,3'd2,8'h01}, {2'd1,4'd2,3'd1,8'h03}, // R1 R2
    {2'd0,4'd6,3'd1,8'h01}, {2'd0,4'd6,3'd2,8'hFE},
    {2'd2,4'd6,3'd0,8'd2},  {2'd1,4'd6,3'd2,8'h00}, {2'd1,4'd6,3'd6,8'h01}, // R6
    {2'd0,4'd1,3'd1,8'h00}, {2'd2,4'd1,3'd0,8'd5},  {2'd1,4'd1,3'd2,8'h00}, // R1
    {2'd0,4'd3,3'd4,8'h02}, {2'd0,4'd3,3'd0,8'h0C}, {2'd0,4'd3,3'd1,8'h01},
    {2'd2,4'd3,3'd0,8'd2},  {2'd3,4'd3,3'd0,8'h02}, {2'd1,4'd10,3'd6,8'h05}, // R3 set
    {2'd0,4'd3,3'd0,8'h00}, {2'd3,4'd3,3'd0,8'h00}                          // R3 off
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input int req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int a = 0; a < 7; a++) rd(11, 3'(a), 8'h00);
    @(negedge clk); check(11, {6'b0, oc_b, oc_a}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][16:15])
        2'd0: wr(VEC[i][10:8], VEC[i][7:0]);
        2'd1: rd(int'(VEC[i][14:11]), VEC[i][10:8], VEC[i][7:0]);
        2'd2: run(int'(VEC[i][7:0]));
        default: begin
          @(negedge clk);
          check(int'(VEC[i][14:11]), {6'b0, oc_b, oc_a}, VEC[i][7:0]);
        end
      endcase
    end

    // R2: writing 0 to prescaler reset leaves the prescaler alone
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h13);
    run(2); wr(3'd1, 8'h03); run(2);
    rd(2, 3'd2, 8'h01);
    // R9: counter write in the middle of counting restarts from written value
    wr(3'd1, 8'h01); wr(3'd2, 8'h40); run(1);
    rd(9, 3'd2, 8'h41);
    // R11: reset again mid-run
    wr(3'd0, 8'h0D); wr(3'd4, 8'h42); run(1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(11, 3'd2, 8'h00);
    rd(11, 3'd6, 8'h00);
    rd(11, 3'd0, 8'h00);
    @(negedge clk); check(11, {6'b0, oc_b, oc_a}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule